// File: doc/BRIEF.md
# Up/Down Event Timer with Capture and Autoreload

This block is a 16-bit timer/counter peripheral. A count-enable tick advances the count while the run bit is set. The count goes up only, or it follows an external direction pin: up while the pin is high, down while it is low. When the count passes its limit, it rolls over to a value taken from a reload register. A falling edge on a separate event pin can copy the live count into that same register (capture), or force the count back to zero (reload). A mode bit picks between the two.

Two sticky flags record rollovers and event-pin hits. Software clears each flag by writing 0 to its bit. An enable bit gates the flags onto a single interrupt line. In clock-output mode, a toggle output changes state on every rollover. The rollover flag is still set in that mode, but it is kept off the interrupt line.

Software reaches three registers through a small synchronous bus: control, value and reload/capture. Both pins pass through a two-stage synchroniser before they are used.

Top module: `updn_event_timer`

## Requirements
- R1: After reset, the control, value and reload registers all read 0000h, and `irq` and `clk_out` are 0.
- R2: While the run bit (control bit 0) is 0, ticks leave the value register unchanged.
- R3: With run set and a tick, an up-count adds 1. From FFFFh, the count loads the reload register and the rollover flag (control bit 6) sets.
- R4: With down mode on (control bit 1) and the synchronised direction pin low, a tick subtracts 1. When the count equals the reload register, the count goes to FFFFh and the rollover flag sets. With the direction pin high, the count goes up.
- R5: With control bit 1 at 0, the count goes up whatever the direction pin is.
- R6: With the external-enable bit (control bit 2) at 0, the event pin changes neither the count, the reload register nor the event flag (control bit 7).
- R7: With external enable set and the capture bit (control bit 3) at 1, an event-pin falling edge copies the count into the reload register and sets the event flag. The count is not disturbed.
- R8: With external enable set and control bit 3 at 0, an event-pin falling edge sets the count to 0000h and sets the event flag.
- R9: Both flags are sticky. Writing 0 to a flag bit through the control register clears it. Writing 1 leaves it unchanged.
- R10: `irq` is the interrupt-enable bit (control bit 4) ANDed with the OR of the event flag and the rollover flag. The rollover flag is masked while clock output (control bit 5) is on.
- R11: With control bit 5 set, `clk_out` toggles on each rollover. With it clear, `clk_out` is 0.
- R12: The bus writes on `bus_wr` at address 0 (control), 1 (value) or 2 (reload). A value write takes effect over any count or event action in the same cycle. `bus_rdata` returns the register at `bus_addr` combinationally.
- R13: A level change on a pin acts on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 control, 1 value, 2 reload |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cnt_tick | input | 1 | Count-enable tick |
| dir_pin | input | 1 | Count direction pin (high = up in down mode) |
| evt_pin | input | 1 | Event pin, acted on at its falling edge |
| clk_out | output | 1 | Clock output, toggles on rollover |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a rollover that meets an event-pin edge or a bus write in the same cycle. Rollovers are 65 536 ticks apart from a random start, and edges arrive three cycles after the pin moves. To reach it, the random phase seeds the value register just below FFFFh, or just above the reload value while counting down. It also toggles the event pin and the bus at random, so that rollovers, edges and writes coincide within a few cycles. A cycle-by-cycle bench model follows the synchroniser delay and the priority of a write over count and event actions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_VAL  = 2'd1;
  localparam logic [1:0] ADDR_REL  = 2'd2;
  localparam int OVF_BIT = 6;
  localparam int EVT_BIT = 7;
  localparam int CTRL_BITS = 6;

  typedef struct packed {
    logic clkout_en;  // bit 5
    logic irq_en;     // bit 4
    logic cap_sel;    // bit 3
    logic ext_en;     // bit 2
    logic down_en;    // bit 1
    logic run;        // bit 0
  } ctrl_t;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign level = chain[STAGES-1];
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         count_up,
  input  logic         zero_req,
  input  logic         load_req,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         rollover
);
  localparam logic [W-1:0] MAXV = '1;

  // {wrap, next value} for one upward step
  function automatic logic [W:0] step_up(input logic [W-1:0] c, input logic [W-1:0] r);
    if (c == MAXV) return {1'b1, r};
    return {1'b0, c + 1'b1};
  endfunction

  // {wrap, next value} for one downward step; passing the reload value wraps
  function automatic logic [W:0] step_down(input logic [W-1:0] c, input logic [W-1:0] r);
    if (c == r) return {1'b1, MAXV};
    return {1'b0, c - 1'b1};
  endfunction

  logic         advance;
  logic [W:0]   step;

  assign advance  = run & tick;
  assign step     = count_up ? step_up(cnt, reload_val) : step_down(cnt, reload_val);
  assign rollover = advance & step[W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (load_req) cnt <= load_val;
    else if (zero_req) cnt <= '0;
    else if (advance)  cnt <= step[W-1:0];

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_req && !zero_req) |=> $stable(cnt));
  a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && count_up && cnt == MAXV && !load_req && !zero_req) |=> cnt == $past(reload_val));
  a_r4_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !count_up && cnt == reload_val && !load_req && !zero_req) |=> cnt == MAXV);
  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req && !load_req) |=> cnt == '0);
endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         evt_lvl,
  input  logic         rollover,
  input  logic [W-1:0] cnt,
  output ctrl_t        ctrl,
  output logic         ovf_flag,
  output logic         evt_flag,
  output logic [W-1:0] reload_val,
  output logic         zero_req,
  output logic         clk_out
);
  logic evt_prev, evt_fall, evt_hit, capture, wr_ctrl, wr_rel;

  assign wr_ctrl  = wr_en && addr == ADDR_CTRL;
  assign wr_rel   = wr_en && addr == ADDR_REL;
  assign evt_fall = evt_prev & ~evt_lvl;
  assign evt_hit  = evt_fall & ctrl.ext_en;
  assign capture  = evt_hit & ctrl.cap_sel;
  assign zero_req = evt_hit & ~ctrl.cap_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_prev <= 1'b0;
    else        evt_prev <= evt_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      ovf_flag <= ((wr_ctrl && !wdata[OVF_BIT]) ? 1'b0 : ovf_flag) | rollover;
      evt_flag <= ((wr_ctrl && !wdata[EVT_BIT]) ? 1'b0 : evt_flag) | evt_hit;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       reload_val <= '0;
    else if (wr_rel)  reload_val <= wdata;
    else if (capture) reload_val <= cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              clk_out <= 1'b0;
    else if (!ctrl.clkout_en) clk_out <= 1'b0;
    else if (rollover)       clk_out <= ~clk_out;

  a_r6_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ext_en |=> !$rose(evt_flag));
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !wr_rel) |=> reload_val == $past(cnt));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !wr_ctrl) |=> ovf_flag);
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.clkout_en |=> !clk_out);
  a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clkout_en && rollover) |=> clk_out != $past(clk_out));
endmodule

// File: rtl/updn_event_timer.sv
module updn_event_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             cnt_tick,
  input  logic             dir_pin,
  input  logic             evt_pin,
  output logic             clk_out,
  output logic             irq
);
  localparam int PAD = WIDTH - EVT_BIT - 1;

  ctrl_t            ctrl;
  logic             dir_lvl, evt_lvl, ovf_flag, evt_flag, zero_req, rollover;
  logic             count_up, load_val;
  logic [WIDTH-1:0] cnt, reload_val;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
    .clk(clk), .rst_n(rst_n), .pin(dir_pin), .level(dir_lvl));
  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .level(evt_lvl));

  assign count_up = ~ctrl.down_en | dir_lvl;
  assign load_val = bus_wr && bus_addr == ADDR_VAL;

  tmr_ctrl_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .evt_lvl(evt_lvl), .rollover(rollover), .cnt(cnt), .ctrl(ctrl),
    .ovf_flag(ovf_flag), .evt_flag(evt_flag), .reload_val(reload_val),
    .zero_req(zero_req), .clk_out(clk_out));

  tmr_count_core #(.W(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(cnt_tick), .count_up(count_up),
    .zero_req(zero_req), .load_req(load_val), .load_val(bus_wdata),
    .reload_val(reload_val), .cnt(cnt), .rollover(rollover));

  assign irq = ctrl.irq_en & (evt_flag | (ovf_flag & ~ctrl.clkout_en));

  always_comb
    case (bus_addr)
      ADDR_CTRL: bus_rdata = {{PAD{1'b0}}, evt_flag, ovf_flag, ctrl};
      ADDR_VAL:  bus_rdata = cnt;
      ADDR_REL:  bus_rdata = reload_val;
      default:   bus_rdata = '0;
    endcase

  a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.irq_en |-> !irq);
  a_r10_clkmode: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.clkout_en && !evt_flag) |-> !irq);
  a_r10_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.irq_en && evt_flag) |-> irq);
endmodule

// File: tb/sim_updn_event_timer.sv
module sim_updn_event_timer;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, cnt_tick = 0, dir_pin = 1, evt_pin = 1;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic clk_out, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  updn_event_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick), .dir_pin(dir_pin),
    .evt_pin(evt_pin), .clk_out(clk_out), .irq(irq));

  // ---- bench reference model, written from the requirements ----
  logic [15:0] m_cnt, m_rel;
  logic [5:0]  m_ctl;
  logic        m_ovf, m_evt, m_clk, m_d1, m_d2, m_dp, m_e1, m_e2, m_ep;

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {8'h00, m_evt, m_ovf, m_ctl};
      2'd1: return m_cnt;
      2'd2: return m_rel;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic m_irq();
    return m_ctl[4] & (m_evt | (m_ovf & ~m_ctl[5]));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_ctl = 0; m_ovf = 0; m_evt = 0; m_clk = 0;
      m_d1 = 0; m_d2 = 0; m_dp = 0; m_e1 = 0; m_e2 = 0; m_ep = 0;
    end else begin
      logic fall, up, roll;
      logic [15:0] nc, nr;
      fall = m_ctl[2] && m_ep && !m_e2;
      up   = !m_ctl[1] || m_d2;
      nc = m_cnt; nr = m_rel; roll = 0;
      if (m_ctl[0] && cnt_tick) begin
        if (up) begin
          if (m_cnt == 16'hFFFF) begin nc = m_rel; roll = 1; end else nc = m_cnt + 1;
        end else begin
          if (m_cnt == m_rel) begin nc = 16'hFFFF; roll = 1; end else nc = m_cnt - 1;
        end
      end
      if (fall && !m_ctl[3]) nc = 0;
      if (fall && m_ctl[3]) nr = m_cnt;
      if (bus_wr && bus_addr == 1) nc = bus_wdata;
      if (bus_wr && bus_addr == 2) nr = bus_wdata;
      if (!m_ctl[5]) m_clk = 0; else if (roll) m_clk = ~m_clk;
      if (bus_wr && bus_addr == 0) begin
        m_ovf = (bus_wdata[6] & m_ovf) | roll;
        m_evt = (bus_wdata[7] & m_evt) | fall;
        m_ctl = bus_wdata[5:0];
      end else begin
        m_ovf = m_ovf | roll;
        m_evt = m_evt | fall;
      end
      m_cnt = nc; m_rel = nr;
      m_dp = m_d2; m_d2 = m_d1; m_d1 = dir_pin;
      m_ep = m_e2; m_e2 = m_e1; m_e1 = evt_pin;
    end
  end

  // ---- helpers ----
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1; idle(n); cnt_tick = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    idle(2); rst_n = 1; idle(1);

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 16'h0);
    rd(1, v); chk("R1 value", v, 16'h0);
    rd(2, v); chk("R1 reload", v, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    chk("R1 clk_out", {15'h0, clk_out}, 16'h0);

    // R12 value write, R2 hold while stopped
    wr(1, 16'h1234); rd(1, v); chk("R12 value write", v, 16'h1234);
    ticks(5); rd(1, v); chk("R2 hold", v, 16'h1234);

    // R3 up count with wrap to reload
    wr(1, 16'hFFFD); wr(2, 16'h0100); wr(0, 16'h0001);
    ticks(3);
    rd(1, v); chk("R3 wrap value", v, 16'h0100);
    rd(0, v); chk("R3 flag", v, 16'h0041);

    // R9 sticky flag
    wr(0, 16'h0041); rd(0, v); chk("R9 write 1 keeps", v, 16'h0041);
    wr(0, 16'h0001); rd(0, v); chk("R9 write 0 clears", v, 16'h0001);

    // R10 / R11 interrupt and clock output
    wr(0, 16'h0011); chk("R10 no flag", {15'h0, irq}, 16'h0);
    wr(1, 16'hFFFF); ticks(1); chk("R10 ovf irq", {15'h0, irq}, 16'h1);
    wr(0, 16'h0071); chk("R10 clk mode mask", {15'h0, irq}, 16'h0);
    chk("R11 idle low", {15'h0, clk_out}, 16'h0);
    wr(1, 16'hFFFF); ticks(1); chk("R11 toggle high", {15'h0, clk_out}, 16'h1);
    wr(1, 16'hFFFF); ticks(1); chk("R11 toggle low", {15'h0, clk_out}, 16'h0);

    // R4 down count with underflow
    wr(0, 16'h0003); dir_pin = 0; idle(3);
    wr(1, 16'h0102); ticks(3);
    rd(1, v); chk("R4 underflow", v, 16'hFFFF);
    rd(0, v); chk("R4 flag", v, 16'h0043);
    // R5 direction ignored without down mode
    wr(0, 16'h0001); wr(1, 16'h0005); ticks(2);
    rd(1, v); chk("R5 up only", v, 16'h0007);
    dir_pin = 1; idle(3);
    wr(0, 16'h0003); wr(1, 16'h0005); ticks(2);
    rd(1, v); chk("R4 dir high up", v, 16'h0007);

    // R6 event pin ignored
    wr(0, 16'h0000); wr(1, 16'h0042);
    evt_pin = 0; idle(4);
    rd(0, v); chk("R6 no flag", v, 16'h0000);
    rd(1, v); chk("R6 value kept", v, 16'h0042);
    rd(2, v); chk("R6 reload kept", v, 16'h0100);
    evt_pin = 1; idle(4);

    // R7 capture, R13 latency
    wr(0, 16'h000C); evt_pin = 0; idle(2);
    rd(2, v); chk("R13 not yet", v, 16'h0100);
    idle(1);
    rd(2, v); chk("R7 captured", v, 16'h0042);
    rd(0, v); chk("R7 flag", v, 16'h008C);
    rd(1, v); chk("R7 count kept", v, 16'h0042);

    // R8 reload to zero on edge
    evt_pin = 1; idle(4);
    wr(0, 16'h0004); wr(1, 16'h0077);
    evt_pin = 0; idle(3);
    rd(1, v); chk("R8 zeroed", v, 16'h0000);
    rd(0, v); chk("R8 flag", v, 16'h0084);
    wr(0, 16'h0094); chk("R10 event irq", {15'h0, irq}, 16'h1);
    wr(0, 16'h0014); chk("R10 cleared", {15'h0, irq}, 16'h0);
    evt_pin = 1; idle(4);

    // random phase against the bench model
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      chk("R12 readback", bus_rdata, m_read(bus_addr));
      chk("R10 irq", {15'h0, irq}, {15'h0, m_irq()});
      chk("R11 clk_out", {15'h0, clk_out}, {15'h0, m_clk});
      r = $urandom;
      cnt_tick = r[0] | r[1];
      if (r[7:4] == 0) dir_pin = ~dir_pin;
      if (r[11:8] < 2) evt_pin = ~evt_pin;
      bus_addr = r[13:12] == 3 ? 2'd1 : r[13:12];
      bus_wr = r[17:14] == 0;
      case (bus_addr)
        2'd0: bus_wdata = {8'h0, r[18] ? 2'b11 : r[20:19], r[21] | r[22], r[26:23], 1'b1};
        2'd1: bus_wdata = r[28] ? (16'hFFF8 | r[31:29]) : (m_rel + r[31:29]);
        default: bus_wdata = $urandom;
      endcase
      @(negedge clk); #1;
    end
    bus_wr = 0;
    summary();
    $finish;
  end
endmodule